// File: doc/BRIEF.md
# Keyhole Bus Transaction Master

This block lets software run single read or write transactions against addressed clients on a shared power-management bus. It exposes four identical command ports, called keyholes, behind a small word-addressed register interface. To issue a transaction, software loads a port's write-data register and then writes that port's control word. The control word carries a start bit, a direction bit, a bus index and a client address. The port then reports busy until the transaction ends. At the end it shows the outcome in sticky timeout and slave-error flags, and it keeps the read data in its own read-data register.

The four ports share one downstream request/acknowledge channel, and a round-robin arbiter decides which port goes next. Each port has a mutex register, so several software agents can agree on who owns it. One timeout register, shared by all ports, limits how many cycles the master waits for an acknowledge.

The register interface takes word indices. Index 0 is the timeout register. Port p starts at index 4+4p, with four registers in this order: control, write data, read data, mutex. Reads return their data one cycle after the read strobe.

Top module: `kh_bus_master`

## Requirements
- R1: After reset every control word reads 0, the timeout register reads its reset value (64), and `req` is low.
- R2: Writing a control word with bit 31 set while the port is idle starts a write or a read. Bit 24 = 1 is a write and bit 24 = 0 is a read. Bits [23:20] are the bus index and bits [19:0] are the address. These fields and the write-data register are presented unchanged on `req_write`, `req_bus`, `req_addr` and `req_wdata`, and they stay stable while `req` is high.
- R3: A read that ends with an acknowledge stores `ack_rdata` in the port's read-data register. A write leaves the read-data register unchanged.
- R4: Control bit 28 (busy) reads 1 from the cycle after start until the transaction ends, and 0 after it ends. While `req` is high, the port that owns the bus is busy.
- R5: If no acknowledge arrives, `req` stays high for exactly max(T,1) cycles, where T is the timeout register value. The transaction then ends with control bit 30 set and the read-data register cleared to 0.
- R6: An acknowledge that comes with `ack_err` high sets control bit 29. The timeout flag is never set on a cycle where an acknowledge arrives.
- R7: Bits 29 and 30 hold their values until the next accepted start on the same port, which clears both.
- R8: A control write to a busy port is ignored. No second transaction is issued, and the port's pending fields stay as they were.
- R9: Each port's mutex read returns 1 to the first reader and takes ownership. While the port is owned, reads return 0. Writing 1 has no effect, and writing a value with bit 0 clear releases the mutex. Each port's mutex is independent of the others.
- R10: Pending ports are granted in round-robin order. The search starts at the port after the one granted last, and at most one port is granted per cycle.
- R11: The timeout register (index 0, bits [15:0]) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 5 | Register word index |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, valid the cycle after `cpu_rd` |
| req | output | 1 | Transaction request to the client bus |
| req_write | output | 1 | 1 = write, 0 = read |
| req_bus | output | 4 | Bus index |
| req_addr | output | 20 | Client address |
| req_wdata | output | 32 | Write data |
| ack | input | 1 | Client acknowledge, one cycle |
| ack_err | input | 1 | Client error, valid with `ack` |
| ack_rdata | input | 32 | Client read data, valid with `ack` |

## Verification
The assertions assume a well-behaved client. It raises `ack` only while `req` is high, and it holds `ack` for one cycle only. The assertions also assume that software does not rewrite the timeout register while a transaction is in flight, because the timeout-window check compares against the live value. The bench client model acknowledges after a programmable count of request cycles, drops `ack` on the next cycle, and can be switched off to force timeouts. The bench changes the timeout register only when all ports are idle.

// File: rtl/kh_pkg.sv
package kh_pkg;
  localparam int START_BIT = 31;
  localparam int TMO_BIT   = 30;
  localparam int ERR_BIT   = 29;
  localparam int BUSY_BIT  = 28;
  localparam int DIR_BIT   = 24;
  localparam int BUS_LSB   = 20;
  localparam int BUS_W     = 4;
  localparam int CADDR_W   = 20;

  typedef struct packed {
    logic               wr;
    logic [BUS_W-1:0]   bus;
    logic [CADDR_W-1:0] addr;
    logic [31:0]        data;
  } cmd_t;

  // Timeout fires on the cycle where the elapsed count reaches the limit.
  function automatic logic tmo_hit(input logic [31:0] cnt, input logic [31:0] limit);
    logic [32:0] nxt;
    nxt = {1'b0, cnt} + 33'd1;
    return nxt >= {1'b0, limit};
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic tmo, input logic err,
                                            input logic busy, input cmd_t c);
    return {1'b0, tmo, err, busy, 3'b000, c.wr, c.bus, c.addr};
  endfunction
endpackage

// File: rtl/kh_port.sv
module kh_port
  import kh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        data_we,
  input  logic        mtx_we,
  input  logic        mtx_re,
  input  logic [31:0] wdata,
  input  logic        launch,
  input  logic        fin,
  input  logic        fin_err,
  input  logic        fin_tmo,
  input  logic [31:0] fin_rdata,
  output logic        pend,
  output logic        busy,
  output cmd_t        cmd,
  output logic [31:0] ctrl_rd,
  output logic [31:0] rdata_q,
  output logic        mtx_rd_val,
  output logic        start_ok
);
  logic act, tmo_q, err_q, owned;

  assign busy       = pend | act;
  assign start_ok   = ctrl_we & wdata[START_BIT] & ~busy;
  assign mtx_rd_val = ~owned;
  assign ctrl_rd    = pack_ctrl(tmo_q, err_q, busy, cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= '0;
      pend    <= 1'b0;
      act     <= 1'b0;
      tmo_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      owned   <= 1'b0;
    end else begin
      if (ctrl_we && !busy) begin
        cmd.wr   <= wdata[DIR_BIT];
        cmd.bus  <= wdata[BUS_LSB +: BUS_W];
        cmd.addr <= wdata[CADDR_W-1:0];
      end
      if (data_we) cmd.data <= wdata;
      if (start_ok) begin
        pend  <= 1'b1;
        tmo_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (launch) begin
        pend <= 1'b0;
        act  <= 1'b1;
      end
      if (fin) begin
        act   <= 1'b0;
        err_q <= fin_err;
        tmo_q <= fin_tmo;
        if (fin_tmo)      rdata_q <= '0;
        else if (!cmd.wr) rdata_q <= fin_rdata;
      end
      if (mtx_re && !owned)           owned <= 1'b1;
      else if (mtx_we && !wdata[0])   owned <= 1'b0;
    end
  end
endmodule

// File: rtl/kh_rr_arb.sv
module kh_rr_arb #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NP-1:0] req,
  output logic [NP-1:0] gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NP; i++) begin
      int j;
      j = (int'(ptr) + i) % NP;
      if (!found && en && req[j]) begin
        found   = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (found)  ptr <= IW'((int'(gnt_idx) + 1) % NP);
  end
endmodule

// File: rtl/kh_bus_eng.sv
module kh_bus_eng
  import kh_pkg::*;
#(
  parameter int NP    = 4,
  parameter int TMO_W = 16,
  localparam int IW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [IW-1:0]    launch_idx,
  input  cmd_t             launch_cmd,
  input  logic [TMO_W-1:0] limit,
  input  logic             ack,
  input  logic             ack_err,
  output logic             idle,
  output logic             req,
  output cmd_t             cur,
  output logic [IW-1:0]    own_idx,
  output logic             fin,
  output logic             fin_err,
  output logic             fin_tmo
);
  logic             act;
  logic [TMO_W-1:0] cnt;
  logic             hit;

  assign hit     = tmo_hit(32'(cnt), 32'(limit));
  assign idle    = ~act;
  assign req     = act;
  assign fin     = act & (ack | hit);
  assign fin_tmo = act & ~ack & hit;
  assign fin_err = act & ack & ack_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      cnt     <= '0;
      own_idx <= '0;
      cur     <= '0;
    end else if (launch) begin
      act     <= 1'b1;
      cnt     <= '0;
      own_idx <= launch_idx;
      cur     <= launch_cmd;
    end else if (act) begin
      if (ack || hit) act <= 1'b0;
      else            cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kh_bus_master.sv
module kh_bus_master
  import kh_pkg::*;
#(
  parameter int NP      = 4,
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_wr,
  input  logic                        cpu_rd,
  input  logic [$clog2(4*NP+4)-1:0]   cpu_addr,
  input  logic [31:0]                 cpu_wdata,
  output logic [31:0]                 cpu_rdata,
  output logic                        req,
  output logic                        req_write,
  output logic [BUS_W-1:0]            req_bus,
  output logic [CADDR_W-1:0]          req_addr,
  output logic [31:0]                 req_wdata,
  input  logic                        ack,
  input  logic                        ack_err,
  input  logic [31:0]                 ack_rdata
);
  localparam int AW = $clog2(4*NP+4);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic [TMO_W-1:0]   tmo_lim;
  logic [NP-1:0]      pend_v, busy_v, gnt_v, fin_v, start_v;
  logic [NP-1:0]      ctrl_we_v, data_we_v, mtx_we_v, mtx_re_v, mtx_val_v;
  logic [IW-1:0]      gnt_idx, own_idx;
  logic               bus_idle, fin, fin_err, fin_tmo;
  cmd_t               cmd_v [NP];
  cmd_t               cur;
  logic [31:0]        ctrl_rd_v [NP];
  logic [31:0]        rdat_v [NP];
  logic [NP*CADDR_W-1:0] addr_flat;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int BASE = 4 + 4*p;
    assign ctrl_we_v[p] = cpu_wr && (cpu_addr == AW'(BASE));
    assign data_we_v[p] = cpu_wr && (cpu_addr == AW'(BASE + 1));
    assign mtx_we_v[p]  = cpu_wr && (cpu_addr == AW'(BASE + 3));
    assign mtx_re_v[p]  = cpu_rd && (cpu_addr == AW'(BASE + 3));
    assign fin_v[p]     = fin && (own_idx == IW'(p));
    assign addr_flat[p*CADDR_W +: CADDR_W] = cmd_v[p].addr;

    kh_port u_port (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(ctrl_we_v[p]), .data_we(data_we_v[p]),
      .mtx_we(mtx_we_v[p]), .mtx_re(mtx_re_v[p]),
      .wdata(cpu_wdata),
      .launch(gnt_v[p]),
      .fin(fin_v[p]), .fin_err(fin_err), .fin_tmo(fin_tmo), .fin_rdata(ack_rdata),
      .pend(pend_v[p]), .busy(busy_v[p]), .cmd(cmd_v[p]),
      .ctrl_rd(ctrl_rd_v[p]), .rdata_q(rdat_v[p]),
      .mtx_rd_val(mtx_val_v[p]), .start_ok(start_v[p])
    );
  end

  kh_rr_arb #(.NP(NP)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(bus_idle), .req(pend_v),
    .gnt(gnt_v), .gnt_idx(gnt_idx)
  );

  kh_bus_eng #(.NP(NP), .TMO_W(TMO_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .launch(|gnt_v), .launch_idx(gnt_idx), .launch_cmd(cmd_v[gnt_idx]),
    .limit(tmo_lim), .ack(ack), .ack_err(ack_err),
    .idle(bus_idle), .req(req), .cur(cur), .own_idx(own_idx),
    .fin(fin), .fin_err(fin_err), .fin_tmo(fin_tmo)
  );

  assign req_write = cur.wr;
  assign req_bus   = cur.bus;
  assign req_addr  = cur.addr;
  assign req_wdata = cur.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             tmo_lim <= TMO_W'(TMO_RST);
    else if (cpu_wr && cpu_addr == '0)      tmo_lim <= cpu_wdata[TMO_W-1:0];
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (cpu_addr == '0) rd_mux = 32'(tmo_lim);
    for (int p = 0; p < NP; p++) begin
      if (cpu_addr == AW'(4 + 4*p))     rd_mux = ctrl_rd_v[p];
      if (cpu_addr == AW'(4 + 4*p + 1)) rd_mux = cmd_v[p].data;
      if (cpu_addr == AW'(4 + 4*p + 2)) rd_mux = rdat_v[p];
      if (cpu_addr == AW'(4 + 4*p + 3)) rd_mux = {31'd0, mtx_val_v[p]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpu_rdata <= '0;
    else if (cpu_rd)  cpu_rdata <= rd_mux;
  end
endmodule

module kh_bus_master_chk #(
  parameter int NP    = 4,
  parameter int TMO_W = 16,
  localparam int IW   = (NP > 1) ? $clog2(NP) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req,
  input logic                  ack,
  input logic                  fin,
  input logic                  fin_tmo,
  input logic [19:0]           req_addr,
  input logic [3:0]            req_bus,
  input logic                  req_write,
  input logic [NP-1:0]         busy_v,
  input logic [NP-1:0]         gnt_v,
  input logic [NP-1:0]         ctrl_we_v,
  input logic [IW-1:0]         own_idx,
  input logic [TMO_W-1:0]      tmo_lim,
  input logic [NP*20-1:0]      addr_flat
);
  logic [TMO_W:0] win;
  logic [TMO_W:0] eff;
  assign eff = (tmo_lim == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win <= '0;
    else if (req) win <= win + 1'b1;
    else          win <= '0;
  end

  a_r5_tmo_window: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> win < eff);
  a_r6_tmo_not_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fin_tmo |-> !ack);
  a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fin) |=> (req && $stable(req_addr) && $stable(req_bus) && $stable(req_write)));
  a_r4_owner_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy_v[own_idx]);
  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_v));
  a_r10_no_grant_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (gnt_v == '0));

  for (genvar p = 0; p < NP; p++) begin : g_ign
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_v[p] && ctrl_we_v[p]) |=> $stable(addr_flat[p*20 +: 20]));
  end
endmodule

bind kh_bus_master kh_bus_master_chk #(.NP(NP), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .fin(fin), .fin_tmo(fin_tmo),
  .req_addr(req_addr), .req_bus(req_bus), .req_write(req_write),
  .busy_v(busy_v), .gnt_v(gnt_v), .ctrl_we_v(ctrl_we_v), .own_idx(own_idx),
  .tmo_lim(tmo_lim), .addr_flat(addr_flat)
);

// File: tb/kh_bus_master_tb.sv
`timescale 1ns/1ps
module kh_bus_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic req, req_write;
  logic [3:0] req_bus;
  logic [19:0] req_addr;
  logic [31:0] req_wdata;
  logic ack = 1'b0, ack_err = 1'b0;
  logic [31:0] ack_rdata = '0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // client model
  bit client_on = 1;
  int lat = 2;
  bit err_resp = 0;
  logic [31:0] rdata_resp = '0;
  int rcnt = 0, req_cyc = 0, n_ack = 0;
  logic [19:0] last_addr, ord [0:7];
  logic [3:0] last_bus;
  logic last_wr;
  logic [31:0] last_wdata;

  always #10 clk = ~clk;

  kh_bus_master u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .req(req), .req_write(req_write),
    .req_bus(req_bus), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .ack_err(ack_err), .ack_rdata(ack_rdata)
  );

  always @(negedge clk) begin
    if (req) req_cyc++;
    if (ack) begin
      ack = 0; ack_err = 0; rcnt = 0;
    end else if (req && client_on) begin
      rcnt++;
      if (rcnt >= lat) begin
        ack = 1; ack_err = err_resp; ack_rdata = rdata_resp;
        last_addr = req_addr; last_bus = req_bus; last_wr = req_write; last_wdata = req_wdata;
        if (n_ack < 8) ord[n_ack] = req_addr;
        n_ack++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int idx, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = 5'(idx); cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic reg_read(input int idx, output logic [31:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = 5'(idx);
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  function automatic int base(input int p); return 4 + 4*p; endfunction
  function automatic logic [31:0] ctl(input bit st, input bit wr, input int bus, input int a);
    return {st, 6'd0, wr, 4'(bus), 20'(a)};
  endfunction

  task automatic wait_idle(input int p);
    logic [31:0] v;
    for (int k = 0; k < 500; k++) begin
      reg_read(base(p), v);
      if (!v[28]) return;
    end
    check("R4 wait idle", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) begin
      reg_read(base(p), v);
      check("R1 ctrl reset", v, 32'd0);
    end
    reg_read(0, v);
    check("R1 timeout reset", v, 32'd64);
    check("R1 req low", {31'd0, req}, 32'd0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    n_ack = 0; lat = 2; err_resp = 0;
    reg_write(base(0) + 1, 32'hDEAD_BEEF);
    reg_write(base(0), ctl(1, 1, 5, 20'h1_2345));
    wait_idle(0);
    check("R2 write addr", {12'd0, last_addr}, 32'h1_2345);
    check("R2 write bus", {28'd0, last_bus}, 32'd5);
    check("R2 write dir", {31'd0, last_wr}, 32'd1);
    check("R2 write data", last_wdata, 32'hDEAD_BEEF);
    reg_read(base(0), v);
    check("R4 busy clear after write", {31'd0, v[28]}, 32'd0);
    reg_read(base(0) + 2, v);
    check("R3 write keeps rdata", v, 32'd0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    lat = 3; rdata_resp = 32'h0BAD_F00D;
    reg_write(base(2), ctl(1, 0, 9, 20'hA_BCDE));
    reg_read(base(2), v);
    check("R4 busy during read", {31'd0, v[28]}, 32'd1);
    wait_idle(2);
    check("R2 read dir", {31'd0, last_wr}, 32'd0);
    check("R2 read addr", {12'd0, last_addr}, 32'hA_BCDE);
    reg_read(base(2) + 2, v);
    check("R3 read data captured", v, 32'h0BAD_F00D);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    reg_write(0, 32'd5);
    reg_read(0, v);
    check("R11 timeout readback", v, 32'd5);
    client_on = 0; req_cyc = 0;
    reg_write(base(2), ctl(1, 0, 1, 20'h00777));
    wait_idle(2);
    check("R5 req window", 32'(req_cyc), 32'd5);
    reg_read(base(2), v);
    check("R5 timeout flag", {31'd0, v[30]}, 32'd1);
    check("R6 no err on timeout", {31'd0, v[29]}, 32'd0);
    reg_read(base(2) + 2, v);
    check("R5 rdata zero", v, 32'd0);
    client_on = 1; reg_write(0, 32'd64);
    reg_write(base(2), ctl(1, 1, 1, 20'h00778));
    reg_read(base(2), v);
    check("R7 timeout cleared on start", {31'd0, v[30]}, 32'd0);
    wait_idle(2);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int acks0;
    lat = 2; err_resp = 1;
    reg_write(base(3), ctl(1, 1, 2, 20'h00333));
    wait_idle(3);
    reg_read(base(3), v);
    check("R6 err flag", {31'd0, v[29]}, 32'd1);
    check("R6 tmo flag clear", {31'd0, v[30]}, 32'd0);
    err_resp = 0; lat = 20; acks0 = n_ack;
    reg_write(base(3), ctl(1, 1, 2, 20'h00444));
    reg_read(base(3), v);
    check("R7 err cleared on start", {31'd0, v[29]}, 32'd0);
    reg_write(base(3), ctl(1, 1, 6, 20'h00999));
    reg_read(base(3), v);
    check("R8 fields kept while busy", {12'd0, v[19:0]}, 32'h00444);
    wait_idle(3);
    repeat (4) @(negedge clk);
    check("R8 single transaction", 32'(n_ack - acks0), 32'd1);
    check("R8 original addr", {12'd0, last_addr}, 32'h00444);
  endtask

  task automatic t_mutex();
    logic [31:0] v;
    reg_read(base(1) + 3, v); check("R9 first reader", v, 32'd1);
    reg_read(base(1) + 3, v); check("R9 second reader", v, 32'd0);
    reg_read(base(0) + 3, v); check("R9 other port free", v, 32'd1);
    reg_write(base(1) + 3, 32'd1);
    reg_read(base(1) + 3, v); check("R9 write 1 no release", v, 32'd0);
    reg_write(base(1) + 3, 32'd0);
    reg_read(base(1) + 3, v); check("R9 release", v, 32'd1);
  endtask

  task automatic t_rr();
    n_ack = 0; lat = 20;
    reg_write(base(1), ctl(1, 1, 0, 20'h00011));
    reg_write(base(0), ctl(1, 1, 0, 20'h00010));
    reg_write(base(2), ctl(1, 1, 0, 20'h00012));
    wait_idle(1); wait_idle(0); wait_idle(2);
    check("R10 order first", {12'd0, ord[0]}, 32'h00011);
    check("R10 order second", {12'd0, ord[1]}, 32'h00012);
    check("R10 order third", {12'd0, ord[2]}, 32'h00010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write();
    t_read();
    t_timeout();
    t_error();
    t_mutex();
    t_rr();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule